// File: doc/BRIEF.md
# Serial EEPROM Boot Loader

After reset this block reads boot configuration once from a three-wire serial EEPROM. It fetches three 16-bit words: a mode word that carries the ganged power-switching flag, a vendor ID and a product ID. The block divides the system clock to make the serial clock. It holds chip select high for the whole transfer. It drives a read command on the shared data line, then lets go of that line so the memory can return the data. When the transfer ends it turns off every output driver, so other logic can use the EEPROM. It then presents the captured words and pulses a done flag.

The read only starts if the memory-enable input is low when reset is released. If that input is high, the bus is never touched. The block then reports fixed default IDs, and it takes the ganged flag from a strap pin.

Top module: `eeprom_boot_loader`

## Requirements
- R1: While `rst_ni` is low, `ctl_oe_o`, `sda_oe_o`, `cs_o`, `done_o` and `cfg_valid_o` are all 0.
- R2: With `rom_en_ni` low at reset release, exactly one transfer runs. `cs_o` and `ctl_oe_o` stay high for all of it, and the serial clock gives exactly 3+ADDR_W+48 rising edges (57 by default).
- R3: The block first drives a 1 start bit, then the opcode bits 1 and 0, then ADDR_W zero address bits, sent in that order. Each bit changes only after a falling serial-clock edge and holds steady while the clock is high.
- R4: After the falling edge that ends the last address bit, `sda_oe_o` is 0 and stays 0. The block never drives the line while the memory is returning data.
- R5: The bit after the address is a dummy bit and is discarded. The next 48 bits are sampled on falling serial-clock edges, most significant bit first, as word 0, then word 1, then word 2.
- R6: `mode_word_o` is word 0, `gang_mode_o` is bit 14 of word 0, `vendor_id_o` is word 1 and `product_id_o` is word 2.
- R7: Once the transfer ends, `ctl_oe_o`, `sda_oe_o` and `cs_o` are 0 and the serial clock makes no more edges.
- R8: `done_o` is high for exactly one cycle per reset, and `cfg_valid_o` rises in that same cycle. The outputs then stay constant until the next reset.
- R9: With `rom_en_ni` high at reset release, the bus drivers stay off. `vendor_id_o` is DEF_VID (default 16'hFACE), `product_id_o` is DEF_PID (default 16'h0B0B), `mode_word_o` is 0 and `gang_mode_o` equals `gang_pin_i`. `cfg_valid_o` is high by the second clock edge after reset release.
- R10: The serial clock period is 2*HALF_DIV system clock cycles (8 by default).
- R11: `rom_en_ni` is only looked at when reset is released. A change during a transfer or after completion does not start, stop or alter a transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rom_en_ni | input | 1 | Low enables the EEPROM read |
| gang_pin_i | input | 1 | Strap value for the ganged flag when the read is disabled |
| sda_i | input | 1 | Resolved level of the shared data line |
| sclk_o | output | 1 | Serial clock level |
| cs_o | output | 1 | EEPROM chip select, active high |
| ctl_oe_o | output | 1 | Output enable for the clock and chip-select pads |
| sda_o | output | 1 | Data value to drive |
| sda_oe_o | output | 1 | Output enable for the data pad |
| done_o | output | 1 | One-cycle pulse when the configuration is ready |
| cfg_valid_o | output | 1 | Configuration outputs are valid |
| mode_word_o | output | WORD_W | Word 0 as read from the EEPROM |
| gang_mode_o | output | 1 | Ganged power-switching flag |
| vendor_id_o | output | WORD_W | Vendor ID |
| product_id_o | output | WORD_W | Product ID |

## Verification
Two actions share the last falling serial-clock edge: sampling the final data bit, and ending the transfer (finish, bus release, capture). The test vectors use product IDs whose least significant bit is 1 and others whose bit is 0. A capture taken one edge too early shows up as a product ID that is shifted or has the wrong low bit. A behavioural EEPROM on the bench responds to the real clock and line. It records the command it received and how many clock pulses it saw, so the number of pulses and the bus release are checked against the count that the requirements give.

// File: rtl/boot_ldr_pkg.sv
`timescale 1ns/1ps
package boot_ldr_pkg;
  localparam int CFG_WORDS = 3;
  localparam logic       RD_START  = 1'b1;
  localparam logic [1:0] RD_OPCODE = 2'b10;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CMD,
    ST_RX,
    ST_FIN
  } ldr_state_e;
endpackage

// File: rtl/boot_sclk_gen.sv
`timescale 1ns/1ps
module boot_sclk_gen #(
  parameter int HALF_DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic sclk_o,
  output logic fall_o
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [CW-1:0] cnt_q;
  logic          sclk_q;
  logic          tick;

  assign tick = run_i && (cnt_q == CW'(HALF_DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
    end else if (tick) begin
      cnt_q  <= '0;
      sclk_q <= ~sclk_q;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign sclk_o = sclk_q;
  // event: the serial clock falls at this edge
  assign fall_o = tick && sclk_q;
endmodule

// File: rtl/boot_rx_shift.sv
`timescale 1ns/1ps
module boot_rx_shift
  import boot_ldr_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic shift_i,
  input  logic bit_i,
  output logic [CFG_WORDS-1:0][WORD_W-1:0] words_o
);
  localparam int TOT = CFG_WORDS * WORD_W;

  logic [TOT-1:0] data_q;
  logic [TOT-1:0] data_nxt;

  assign data_nxt = {data_q[TOT-2:0], bit_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      data_q <= '0;
    else if (shift_i) data_q <= data_nxt;
  end

  // lookahead view so the final bit is capturable on the same edge
  for (genvar k = 0; k < CFG_WORDS; k++) begin : g_word
    assign words_o[k] = data_nxt[(CFG_WORDS-1-k)*WORD_W +: WORD_W];
  end
endmodule

// File: rtl/boot_ldr_seq.sv
`timescale 1ns/1ps
module boot_ldr_seq
  import boot_ldr_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int WORD_W = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rom_en_ni,
  input  logic fall_i,
  output logic run_o,
  output logic sda_o,
  output logic sda_oe_o,
  output logic shift_o,
  output logic finish_o,
  output logic from_rom_o
);
  localparam int CMD_BITS = 3 + ADDR_W;
  localparam int LAST     = CMD_BITS + CFG_WORDS * WORD_W - 1;
  localparam int CNT_W    = $clog2(LAST + 2);
  localparam logic [CMD_BITS-1:0] CMD_VEC = {RD_START, RD_OPCODE, {ADDR_W{1'b0}}};

  ldr_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q;
  logic             cmd_end, rx_end, active;
  logic [CMD_BITS-1:0] cmd_sh;

  assign cmd_end = (cnt_q == CNT_W'(CMD_BITS - 1));
  assign rx_end  = (cnt_q == CNT_W'(LAST));
  assign active  = (state_q == ST_CMD) || (state_q == ST_RX);

  always_comb begin
    state_d  = state_q;
    finish_o = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (rom_en_ni) begin
          state_d  = ST_FIN;
          finish_o = 1'b1;
        end else begin
          state_d  = ST_CMD;
        end
      end
      ST_CMD:  if (fall_i && cmd_end) state_d = ST_RX;
      ST_RX: begin
        if (fall_i && rx_end) begin
          state_d  = ST_FIN;
          finish_o = 1'b1;
        end
      end
      default: state_d = ST_FIN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      if (active && fall_i) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cmd_sh     = CMD_VEC << cnt_q;
  assign run_o      = active;
  assign sda_oe_o   = (state_q == ST_CMD);
  assign sda_o      = sda_oe_o && cmd_sh[CMD_BITS-1];
  // dummy bit falls in ST_CMD's last fall, so it is never shifted
  assign shift_o    = (state_q == ST_RX) && fall_i;
  assign from_rom_o = (state_q == ST_RX);
endmodule

// File: rtl/eeprom_boot_loader.sv
`timescale 1ns/1ps
module eeprom_boot_loader
  import boot_ldr_pkg::*;
#(
  parameter int          HALF_DIV = 4,
  parameter int          ADDR_W   = 6,
  parameter int          WORD_W   = 16,
  parameter int          GANG_BIT = 14,
  parameter logic [15:0] DEF_VID  = 16'hFACE,
  parameter logic [15:0] DEF_PID  = 16'h0B0B
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rom_en_ni,
  input  logic              gang_pin_i,
  input  logic              sda_i,
  output logic              sclk_o,
  output logic              cs_o,
  output logic              ctl_oe_o,
  output logic              sda_o,
  output logic              sda_oe_o,
  output logic              done_o,
  output logic              cfg_valid_o,
  output logic [WORD_W-1:0] mode_word_o,
  output logic              gang_mode_o,
  output logic [WORD_W-1:0] vendor_id_o,
  output logic [WORD_W-1:0] product_id_o
);
  logic run, fall, shift, finish, from_rom;
  logic [CFG_WORDS-1:0][WORD_W-1:0] words;

  boot_sclk_gen #(.HALF_DIV(HALF_DIV)) u_clk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .sclk_o (sclk_o),
    .fall_o (fall)
  );

  boot_ldr_seq #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rom_en_ni  (rom_en_ni),
    .fall_i     (fall),
    .run_o      (run),
    .sda_o      (sda_o),
    .sda_oe_o   (sda_oe_o),
    .shift_o    (shift),
    .finish_o   (finish),
    .from_rom_o (from_rom)
  );

  boot_rx_shift #(.WORD_W(WORD_W)) u_rx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .shift_i (shift),
    .bit_i   (sda_i),
    .words_o (words)
  );

  assign cs_o     = run;
  assign ctl_oe_o = run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o       <= 1'b0;
      cfg_valid_o  <= 1'b0;
      mode_word_o  <= '0;
      gang_mode_o  <= 1'b0;
      vendor_id_o  <= '0;
      product_id_o <= '0;
    end else begin
      done_o <= finish;
      if (finish) begin
        cfg_valid_o <= 1'b1;
        if (from_rom) begin
          mode_word_o  <= words[0];
          gang_mode_o  <= words[0][GANG_BIT];
          vendor_id_o  <= words[1];
          product_id_o <= words[2];
        end else begin
          mode_word_o  <= '0;
          gang_mode_o  <= gang_pin_i;
          vendor_id_o  <= WORD_W'(DEF_VID);
          product_id_o <= WORD_W'(DEF_PID);
        end
      end
    end
  end
endmodule

// File: rtl/boot_ldr_chk.sv
`timescale 1ns/1ps
module boot_ldr_chk #(
  parameter int WORD_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sclk_o,
  input logic              cs_o,
  input logic              ctl_oe_o,
  input logic              sda_o,
  input logic              sda_oe_o,
  input logic              done_o,
  input logic              cfg_valid_o,
  input logic [WORD_W-1:0] mode_word_o,
  input logic              gang_mode_o,
  input logic [WORD_W-1:0] vendor_id_o,
  input logic [WORD_W-1:0] product_id_o
);
  a_r8_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r8_done_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> cfg_valid_o);

  a_r8_cfg_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_valid_o && $past(cfg_valid_o)) |->
      ($stable(mode_word_o) && $stable(vendor_id_o) &&
       $stable(product_id_o) && $stable(gang_mode_o)));

  a_r7_bus_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_valid_o |-> (!ctl_oe_o && !sda_oe_o && !cs_o));

  a_r4_drive_in_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sda_oe_o |-> (ctl_oe_o && cs_o));

  a_r3_data_steady_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sda_oe_o && sclk_o) |-> $stable(sda_o));

  a_r7_no_clock_after: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_valid_o |-> !sclk_o);
endmodule

bind eeprom_boot_loader boot_ldr_chk #(.WORD_W(WORD_W)) u_chk (.*);

// File: tb/eeprom_boot_loader_bench.sv
`timescale 1ns/1ps
module eeprom_boot_loader_bench;
  localparam int HALF = 4;
  localparam int NRISE = 57;
  localparam logic [15:0] DVID = 16'hFACE;
  localparam logic [15:0] DPID = 16'h0B0B;
  localparam logic [47:0] VEC [4] = '{
    48'h4000_A5C3_1235,
    48'h0000_FFFF_0001,
    48'h7FFF_8001_FFFE,
    48'h0000_0000_0000
  };

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, rom_en_n, gang_pin, sda_line;
  logic sclk, cs, ctl_oe, sda_o, sda_oe, done, valid, gang;
  logic [15:0] mode_w, vid, pid;

  eeprom_boot_loader u_eeprom_boot_loader (
    .clk_i(clk), .rst_ni(rst_n), .rom_en_ni(rom_en_n), .gang_pin_i(gang_pin),
    .sda_i(sda_line), .sclk_o(sclk), .cs_o(cs), .ctl_oe_o(ctl_oe),
    .sda_o(sda_o), .sda_oe_o(sda_oe), .done_o(done), .cfg_valid_o(valid),
    .mode_word_o(mode_w), .gang_mode_o(gang), .vendor_id_o(vid),
    .product_id_o(pid)
  );

  // behavioural EEPROM with weak pulldown on the shared lines
  logic mdl_clr;
  int rise_cnt, cyc, r0_cyc, r1_cyc, done_cnt;
  logic [8:0] cmd_seen;
  logic late_drive, eep_bit;
  logic [47:0] eep_data;
  wire sclk_line = ctl_oe ? sclk : 1'b0;
  wire cs_line   = ctl_oe ? cs : 1'b0;
  wire eep_oe    = cs_line && (rise_cnt >= 9) && !sda_oe;
  assign sda_line = sda_oe ? sda_o : (eep_oe ? eep_bit : 1'b0);

  always @(posedge clk) cyc <= cyc + 1;
  initial cyc = 0;

  always @(posedge clk) begin
    if (!rst_n) done_cnt <= 0;
    else if (done) done_cnt <= done_cnt + 1;
  end

  always @(posedge sclk_line or posedge mdl_clr) begin
    if (mdl_clr) begin
      rise_cnt <= 0; cmd_seen <= '0; late_drive <= 1'b0; eep_bit <= 1'b0;
    end else if (cs_line) begin
      if (rise_cnt < 9) cmd_seen <= {cmd_seen[7:0], sda_line};
      if (rise_cnt >= 9 && sda_oe) late_drive <= 1'b1;
      if (rise_cnt == 8) eep_bit <= 1'b0;
      else if (rise_cnt >= 9 && rise_cnt <= 56) eep_bit <= eep_data[47-(rise_cnt-9)];
      if (rise_cnt == 0) r0_cyc <= cyc;
      if (rise_cnt == 1) r1_cyc <= cyc;
      rise_cnt <= rise_cnt + 1;
    end
  end

  int tests = 0, fails = 0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input bit check_r1);
    rst_n = 1'b0; mdl_clr = 1'b1;
    repeat (3) @(negedge clk);
    if (check_r1) begin
      // R1: reset state
      chk("R1 oe", {ctl_oe, sda_oe, cs}, 3'b000);
      chk("R1 flags", {done, valid}, 2'b00);
    end
    mdl_clr = 1'b0;
    rst_n = 1'b1;
  endtask

  task automatic wait_valid();
    for (int n = 0; n < 5000 && !valid; n++) @(negedge clk);
  endtask

  initial begin
    #700000;
    fails++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  logic [15:0] s_vid, s_pid, s_mode;
  int dc;

  initial begin
    rst_n = 1'b0; rom_en_n = 1'b0; gang_pin = 1'b0; mdl_clr = 1'b1; eep_data = '0;

    for (int i = 0; i < 4; i++) begin
      eep_data = VEC[i];
      rom_en_n = 1'b0;
      gang_pin = ~VEC[i][46];
      do_reset(i == 0);
      wait_valid();
      repeat (20) @(negedge clk);
      chk("R3 command", cmd_seen, 9'b110000000);
      chk("R2 pulse count", rise_cnt, NRISE);
      chk("R4 no late drive", late_drive, 1'b0);
      chk("R5/R6 mode word", mode_w, VEC[i][47:32]);
      chk("R6 gang bit14", gang, VEC[i][46]);
      chk("R5/R6 vendor", vid, VEC[i][31:16]);
      chk("R5/R6 product", pid, VEC[i][15:0]);
      chk("R7 released", {ctl_oe, sda_oe, cs}, 3'b000);
      chk("R8 one done", done_cnt, 1);
      if (i == 0) chk("R10 period", r1_cyc - r0_cyc, 2 * HALF);
      if (i == 1) begin
        // R8/R7: hold after completion, no further clocking
        s_vid = vid; s_pid = pid; s_mode = mode_w;
        rom_en_n = 1'b1;
        repeat (150) @(negedge clk);
        chk("R8 vid held", vid, s_vid);
        chk("R8 pid held", pid, s_pid);
        chk("R8 mode held", mode_w, s_mode);
        chk("R11 no rerun", rise_cnt, NRISE);
        chk("R8 done count", done_cnt, 1);
      end
    end

    // R11: enable rises mid transfer, transfer completes unchanged
    eep_data = VEC[0];
    rom_en_n = 1'b0;
    do_reset(1'b0);
    for (int n = 0; n < 2000 && rise_cnt < 5; n++) @(negedge clk);
    rom_en_n = 1'b1;
    wait_valid();
    repeat (5) @(negedge clk);
    chk("R11 mid vid", vid, VEC[0][31:16]);
    chk("R11 mid count", rise_cnt, NRISE);

    // R9: disabled, both strap values
    for (int g = 0; g < 2; g++) begin
      rom_en_n = 1'b1;
      gang_pin = g[0];
      eep_data = 48'hFFFF_FFFF_FFFF;
      do_reset(1'b1);
      @(negedge clk); @(negedge clk);
      chk("R9 valid", valid, 1'b1);
      chk("R9 vid", vid, DVID);
      chk("R9 pid", pid, DPID);
      chk("R9 mode", mode_w, 16'h0000);
      chk("R9 gang strap", gang, g[0]);
      rom_en_n = 1'b0;
      repeat (100) @(negedge clk);
      chk("R9/R11 no bus", {ctl_oe, sda_oe, cs}, 3'b000);
      chk("R11 no pulses", rise_cnt, 0);
      dc = done_cnt;
      chk("R8 single done", dc, 1);
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule